// File: doc/BRIEF.md
# 100 Mb/s Transmit Symbol Encoder

This block turns a stream of 4-bit transmit nibbles into the three-level line code of a 100 Mb/s twisted-pair link. It runs entirely on the 125 MHz bit clock.

An internal divide-by-five phase counter raises `nib_take` for one cycle in every five. The nibble inputs and the mode inputs are captured on the clock edge that ends that cycle.

Each captured nibble becomes a 5-bit code group. Outside a frame the group is the idle symbol. A frame opens with a start-delimiter pair and closes with an end-delimiter pair, and an error flag inside a frame substitutes a halt symbol. The code groups are sent most significant bit first, XORed bit by bit with an 11-bit key stream, NRZI coded, and finally mapped onto three line levels.

A bypass control lets a media-independent-interface MAC supply the five code bits itself: the error flag becomes the fifth bit. The bypass is ignored when the MAC side runs in reduced-pin mode.

Top module: `tx5b_encoder`

## Requirements
- R1: Out of reset `mlt3` is 0 and `nib_take` is low. After reset `nib_take` is high exactly one cycle in every five, and its first high cycle is the fifth cycle after reset is released.
- R2: While no frame is active, every code group is the idle symbol 11111.
- R3: When `tx_en` is seen high at a capture with no frame active, J (11000) is sent in place of that nibble and K (10001) in place of the next nibble, whatever the inputs are at that second capture.
- R4: Inside a frame, a captured nibble with `tx_en` high and `tx_er` low is sent as its 4B/5B group: 0 11110, 1 01001, 2 10100, 3 10101, 4 01010, 5 01011, 6 01110, 7 01111, 8 10010, 9 10011, A 10110, B 10111, C 11010, D 11011, E 11100, F 11101. The left-hand bit is the code bit sent first.
- R5: The first capture inside a frame that sees `tx_en` low sends T (01101). The next group is R (00111), and idle symbols follow. A rise of `tx_en` during the R slot opens a new frame at the following capture.
- R6: Inside a frame, `tx_er` high together with `tx_en` high sends the halt group 00100 instead of the data nibble. `tx_er` has no effect while no frame is active.
- R7: With `enc_bypass` and `mii_mode` both high, the group is {`tx_er`, `txd[3:0]`}, with `tx_er` sent first and no framing applied. The framing returns to the no-frame state.
- R8: With `mii_mode` low, `enc_bypass` has no effect, and the output equals that of normal encoding.
- R9: Every bit period, the key bit k = s[10] XOR s[8] of an 11-bit state s (polynomial x^11 + x^9 + 1) is XORed with the code bit. s then shifts left with k entering at bit 0. s is loaded with the non-zero parameter `SCR_SEED` at reset and advances in every cycle, idle included.
- R10: A scrambled 1 toggles an NRZI level. Each NRZI toggle moves `mlt3` one step through the cycle 0, +1, 0, -1, two clock edges after the cycle of the scrambled bit. `mlt3` never jumps between +1 and -1, and it leaves 0 in the opposite direction from its previous excursion.
- R11: `mlt3` is a signed 2-bit value (+1 = 01, 0 = 00, -1 = 11) and never shows 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Frame-valid for the nibble being captured |
| tx_er | input | 1 | Transmit error flag; fifth code bit in bypass |
| txd | input | 4 | Transmit nibble |
| mii_mode | input | 1 | 1 = MAC side in full media-independent mode, which permits bypass |
| enc_bypass | input | 1 | 1 = skip 4B/5B coding (honoured only with `mii_mode`) |
| nib_take | output | 1 | High in the cycle whose closing edge captures the inputs |
| mlt3 | output | 2 | Signed three-level line output |

## Verification
A wrong framing state or a wrong table entry changes the plaintext of a whole group. Because the key stream is deterministic, that error shows up as a level-sequence mismatch on `mlt3` within two to seven cycles of the affected capture.

A fault in the key register or in the NRZI stage desynchronises the output from the reference. The mismatch appears within a few cycles and persists.

A divider fault shows at once in the spacing of `nib_take`. A faulty MLT-3 state shows as an illegal code or as a direct jump between the outer levels on the very next edge.

// File: rtl/tx5b_pkg.sv
// Package: shared symbol constants, framing states and the nibble-to-group
// table for the 100 Mb/s transmit encoder. The left-hand (MSB) code bit is sent first.
package tx5b_pkg;
    localparam int SYM_W  = 5;
    localparam int NIB_W  = 4;
    localparam int KEY_W  = 11;
    localparam int KEY_TAP = 9;

    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
    localparam logic [SYM_W-1:0] SYM_HALT = 5'b00100;

    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_OPEN2 = 2'd1,
        FR_BODY  = 2'd2,
        FR_CLOSE2 = 2'd3
    } frame_st_t;

    function automatic logic [SYM_W-1:0] nib_to_grp(input logic [NIB_W-1:0] n);
        logic [SYM_W-1:0] g;
        case (n)
            4'h0: g = 5'b11110;  4'h1: g = 5'b01001;
            4'h2: g = 5'b10100;  4'h3: g = 5'b10101;
            4'h4: g = 5'b01010;  4'h5: g = 5'b01011;
            4'h6: g = 5'b01110;  4'h7: g = 5'b01111;
            4'h8: g = 5'b10010;  4'h9: g = 5'b10011;
            4'hA: g = 5'b10110;  4'hB: g = 5'b10111;
            4'hC: g = 5'b11010;  4'hD: g = 5'b11011;
            4'hE: g = 5'b11100;  default: g = 5'b11101;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/tx5b_framer.sv
// Framer: divides the bit clock by the group width, captures a nibble and
// the mode inputs on the last bit of each group, picks the next code group
// (idle, delimiters, data, halt or bypass) and shifts it out MSB first.
// Assumes inputs are stable on the capture edge.
module tx5b_framer
    import tx5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    input  logic             bypass_eff,
    output logic             nib_take,
    output logic             code_bit
);
    localparam int PH_W = $clog2(SYM_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

    logic [PH_W-1:0]  ph;
    logic [SYM_W-1:0] sh;
    frame_st_t        st, st_nxt;
    logic [SYM_W-1:0] grp_nxt;

    assign nib_take = (ph == PH_LAST);
    assign code_bit = sh[SYM_W-1];

    // Purpose: choose the next code group and framing state from the captured inputs.
    always_comb begin
        st_nxt  = st;
        grp_nxt = SYM_IDLE;
        if (bypass_eff) begin
            grp_nxt = {tx_er, txd};
            st_nxt  = FR_NONE;
        end else begin
            case (st)
                FR_NONE: if (tx_en) begin
                    grp_nxt = SYM_J;
                    st_nxt  = FR_OPEN2;
                end
                FR_OPEN2: begin
                    grp_nxt = SYM_K;
                    st_nxt  = FR_BODY;
                end
                FR_BODY: begin
                    if (!tx_en) begin
                        grp_nxt = SYM_T;
                        st_nxt  = FR_CLOSE2;
                    end else if (tx_er) begin
                        grp_nxt = SYM_HALT;
                    end else begin
                        grp_nxt = nib_to_grp(txd);
                    end
                end
                default: begin
                    grp_nxt = SYM_R;
                    st_nxt  = FR_NONE;
                end
            endcase
        end
    end

    // Purpose: advance the bit phase, load a new group at the boundary, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
            sh <= SYM_IDLE;
            st <= FR_NONE;
        end else if (nib_take) begin
            ph <= '0;
            sh <= grp_nxt;
            st <= st_nxt;
        end else begin
            ph <= ph + 1'b1;
            sh <= {sh[SYM_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/tx5b_scrambler.sv
// Key-stream scrambler: an additive stream cipher built on an LFSR with
// taps at the top bit and bit TAP-1 (x^W + x^TAP + 1). It advances every cycle.
// Assumes SEED is non-zero, otherwise the key stream would be all zero.
module tx5b_scrambler #(
    parameter int          W    = 11,
    parameter int          TAP  = 9,
    parameter logic [W-1:0] SEED = 11'h5A3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [W-1:0] s;
    logic         key;

    assign key  = s[W-1] ^ s[TAP-1];
    assign dout = din ^ key;

    // Purpose: step the key register once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) s <= SEED;
        else        s <= {s[W-2:0], key};
    end
endmodule

// File: rtl/tx5b_mlt3.sv
// Line coder: NRZI-toggles on each 1 of the scrambled stream, then steps
// the three-level output once per NRZI change through 0, +1, 0, -1.
// Output is a signed 2-bit level; latency is two edges from the input bit.
module tx5b_mlt3 #(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] LV_ZERO = '0;
    localparam logic [LVL_W-1:0] LV_POS  = LVL_W'(1);
    localparam logic [LVL_W-1:0] LV_NEG  = '1;

    logic       nrzi_q, nrzi_d;
    logic [1:0] idx;

    // Purpose: NRZI stage, toggling on a 1.
    always_ff @(posedge clk) begin
        if (!rst_n) nrzi_q <= 1'b0;
        else        nrzi_q <= nrzi_q ^ din;
    end

    // Purpose: MLT-3 stage, stepping on each change of the NRZI level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrzi_d <= 1'b0;
            idx    <= 2'd0;
        end else begin
            nrzi_d <= nrzi_q;
            if (nrzi_q != nrzi_d) idx <= idx + 2'd1;
        end
    end

    // Purpose: map the step index onto the signed level.
    always_comb begin
        case (idx)
            2'd1:    level = LV_POS;
            2'd3:    level = LV_NEG;
            default: level = LV_ZERO;
        endcase
    end
endmodule

// File: rtl/tx5b_encoder.sv
// Top: 100 Mb/s transmit path from nibbles to three-level line code on one
// 125 MHz clock. The bypass is honoured only when the MAC side is in full
// media-independent mode. Synchronous active-low reset.
module tx5b_encoder
    import tx5b_pkg::*;
#(
    parameter logic [KEY_W-1:0] SCR_SEED = 11'h5A3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    input  logic             mii_mode,
    input  logic             enc_bypass,
    output logic             nib_take,
    output logic [1:0]       mlt3
);
    logic code_bit, scr_bit, bypass_eff;

    assign bypass_eff = enc_bypass & mii_mode;

    tx5b_framer u_framer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .bypass_eff(bypass_eff), .nib_take(nib_take), .code_bit(code_bit)
    );

    tx5b_scrambler #(.W(KEY_W), .TAP(KEY_TAP), .SEED(SCR_SEED)) u_scr (
        .clk(clk), .rst_n(rst_n), .din(code_bit), .dout(scr_bit)
    );

    tx5b_mlt3 #(.LVL_W(2)) u_line (
        .clk(clk), .rst_n(rst_n), .din(scr_bit), .level(mlt3)
    );
endmodule

// File: rtl/tx5b_encoder_chk.sv
// Checker: port-level properties of the encoder, bound to every instance.
module tx5b_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nib_take,
    input logic [1:0] mlt3
);
    logic [2:0] gap;
    logic [1:0] last_nz;
    logic       has_nz;

    // Purpose: count cycles since the last capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap <= 3'd0;
        else if (nib_take) gap <= 3'd0;
        else               gap <= gap + 3'd1;
    end

    // Purpose: remember the most recent non-zero line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_nz  <= 1'b0;
            last_nz <= 2'b00;
        end else if (mlt3 != 2'b00) begin
            has_nz  <= 1'b1;
            last_nz <= mlt3;
        end
    end

    p_take_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |-> gap == 3'd4);
    p_take_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gap == 3'd4 |-> nib_take);
    p_level_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mlt3 != 2'b10);
    p_no_rail_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(mlt3) == 2'b01 && mlt3 == 2'b11) ||
          ($past(mlt3) == 2'b11 && mlt3 == 2'b01)));
    p_alternate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (has_nz && $past(mlt3) == 2'b00 && mlt3 != 2'b00) |-> mlt3 != last_nz);
endmodule

bind tx5b_encoder tx5b_encoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nib_take(nib_take), .mlt3(mlt3)
);

// File: tb/tx5b_encoder_test.sv
// Directed bench: a reference model built from the requirements runs next
// to the encoder, and each scenario task checks the line output against it.
module tx5b_encoder_test;
    localparam logic [10:0] SEED = 11'h5A3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_er = 1'b0, mii_mode = 1'b0, enc_bypass = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       nib_take;
    logic [1:0] mlt3;

    int checks = 0, errors = 0;
    int mism = 0, bad_lvl = 0, takes = 0, moves = 0;
    logic [1:0] f_act, f_exp;
    logic [1:0] prev_lvl = 2'b00;

    always #4 clk = ~clk;

    tx5b_encoder #(.SCR_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .mii_mode(mii_mode), .enc_bypass(enc_bypass),
        .nib_take(nib_take), .mlt3(mlt3)
    );

    // Reference model, written from R1 to R11.
    logic [2:0]  m_ph;
    logic [4:0]  m_sh;
    logic [1:0]  m_st;
    logic [10:0] m_lfsr;
    logic        m_nrzi, m_nd, m_key;
    logic [1:0]  m_idx;
    logic [4:0]  m_grp;

    function automatic logic [4:0] ref_grp(input logic [3:0] n);
        logic [79:0] tbl = {5'b11101, 5'b11100, 5'b11011, 5'b11010,
                            5'b10111, 5'b10110, 5'b10011, 5'b10010,
                            5'b01111, 5'b01110, 5'b01011, 5'b01010,
                            5'b10101, 5'b10100, 5'b01001, 5'b11110};
        return tbl[n*5 +: 5];
    endfunction

    function automatic logic [1:0] ref_lvl(input logic [1:0] i);
        return (i == 2'd1) ? 2'b01 : (i == 2'd3) ? 2'b11 : 2'b00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_sh <= 5'b11111; m_st <= 0; m_lfsr <= SEED;
            m_nrzi <= 0; m_nd <= 0; m_idx <= 0;
        end else begin
            m_key = m_lfsr[10] ^ m_lfsr[8];
            m_lfsr <= {m_lfsr[9:0], m_key};
            m_nrzi <= m_nrzi ^ (m_sh[4] ^ m_key);
            m_nd <= m_nrzi;
            if (m_nrzi != m_nd) m_idx <= m_idx + 2'd1;
            if (m_ph == 3'd4) begin
                m_ph <= 0;
                if (enc_bypass && mii_mode) begin
                    m_grp = {tx_er, txd}; m_st <= 0;
                end else if (m_st == 0) begin
                    m_grp = tx_en ? 5'b11000 : 5'b11111;
                    if (tx_en) m_st <= 1;
                end else if (m_st == 1) begin
                    m_grp = 5'b10001; m_st <= 2;
                end else if (m_st == 2) begin
                    if (!tx_en) begin m_grp = 5'b01101; m_st <= 3; end
                    else m_grp = tx_er ? 5'b00100 : ref_grp(txd);
                end else begin
                    m_grp = 5'b00111; m_st <= 0;
                end
                m_sh <= m_grp;
            end else begin
                m_ph <= m_ph + 3'd1;
                m_sh <= {m_sh[3:0], 1'b0};
            end
        end
    end

    // Output comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mlt3 != ref_lvl(m_idx) || nib_take != (m_ph == 3'd4)) begin
                if (mism == 0) begin f_act = mlt3; f_exp = ref_lvl(m_idx); end
                mism++;
            end
            if (mlt3 == 2'b10) bad_lvl++;
            if (nib_take) takes++;
            if (mlt3 != prev_lvl) moves++;
            prev_lvl = mlt3;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check(mism == 0, req, int'(f_act), int'(f_exp));
    endtask

    task automatic send(input logic en, input logic er, input logic [3:0] d);
        do @(negedge clk); while (!nib_take);
        tx_en = en; tx_er = er; txd = d;
    endtask

    task automatic idle_groups(input int n);
        for (int i = 0; i < n; i++) send(1'b0, 1'b0, 4'h0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(mlt3 == 2'b00, "R1 reset level", mlt3, 0);
        check(nib_take == 1'b0, "R1 reset strobe", nib_take, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(nib_take == 1'b1, "R1 first strobe on fifth cycle", nib_take, 1);
    endtask

    task automatic t_idle();
        mism = 0; takes = 0; moves = 0;
        repeat (60) @(negedge clk);
        check(takes == 12, "R1 strobe rate", takes, 12);
        check_model("R2 R9 R10 idle stream");
        check(moves > 0, "R10 line activity on idle", moves, 1);
    endtask

    task automatic t_frame();
        mism = 0;
        for (int i = 0; i < 16; i++) send(1'b1, 1'b0, 4'(i));
        idle_groups(4);
        check_model("R3 R4 R5 frame of all nibbles");
        mism = 0;
        for (int i = 0; i < 10; i++) send(1'b1, 1'b0, 4'(15 - i) ^ 4'h5);
        send(1'b0, 1'b0, 4'h0);
        send(1'b1, 1'b0, 4'h3);   // rise during R slot: ignored there
        send(1'b1, 1'b0, 4'h9);
        idle_groups(4);
        check_model("R4 R5 second pattern and back-to-back frame");
    endtask

    task automatic t_error();
        mism = 0;
        send(1'b1, 1'b0, 4'h5); send(1'b1, 1'b0, 4'h5);
        send(1'b1, 1'b1, 4'hA); send(1'b1, 1'b0, 4'h7);
        idle_groups(3);
        check_model("R6 halt inside frame");
        mism = 0;
        send(1'b0, 1'b1, 4'hC); send(1'b0, 1'b1, 4'h1);
        idle_groups(3);
        check_model("R6 error flag outside frame ignored");
    endtask

    task automatic t_short();
        mism = 0;
        send(1'b1, 1'b1, 4'h2);
        send(1'b0, 1'b1, 4'h2);   // K slot ignores inputs
        idle_groups(4);
        check_model("R3 R5 one-nibble frame");
    endtask

    task automatic t_bypass();
        mism = 0;
        mii_mode = 1'b1; enc_bypass = 1'b1;
        for (int i = 0; i < 12; i++) send(1'(i % 3 == 0), 1'(i[0]), 4'(i * 7));
        enc_bypass = 1'b0;
        idle_groups(3);
        check_model("R7 bypass in full mode");
        mism = 0;
        mii_mode = 1'b0; enc_bypass = 1'b1;
        for (int i = 0; i < 8; i++) send(1'b1, 1'(i == 4), 4'(i + 3));
        idle_groups(4);
        enc_bypass = 1'b0;
        check_model("R8 bypass ignored in reduced mode");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_frame();
        t_error();
        t_short();
        t_bypass();
        check(bad_lvl == 0, "R11 level codes", bad_lvl, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule